// File: doc/BRIEF.md
# PWM Output Disable Controller

This block sits between a timer's waveform generator and four output pins, A to D. It holds one 8-bit control register. Each of the four low bits chooses, for its own pin, whether the raw timer waveform reaches the pin or the pin is taken out of service. A mode input selects what "out of service" means. In normal mode the pin's output enable is dropped, so the pin floats. In manipulation mode the pin keeps driving, but it drives a fixed level that is supplied from outside the block.

Bit 7 arms a hardware shutdown path. While it is armed and manipulation mode is off, a low level on an external interrupt pin sets all four disable bits, and keeps setting them while the pin stays low. That pin is not synchronous to the clock, so it passes through a two-flop synchronizer before it is used. Software reads the register back as it stands, including any bits the shutdown path has set.

Top module: `pwm_outdis_ctrl`

## Requirements
- R1: After reset the register reads 0x7F: bits 3:0 (disable bits for pins A=bit0, B=bit1, C=bit2, D=bit3) are 1, bits 6:4 are 1 and bit 7 (shutdown arm) is 0.
- R2: Bits 6:4 always read 1, whatever value is written to them.
- R3: A write with no shutdown force active loads bits 3:0 of the write data into the disable bits. The new value is visible one cycle later.
- R4: Every write loads bit 7 of the write data into the shutdown arm bit.
- R5: In normal mode (manip_mode=0), a pin whose disable bit is 1 has pin_oe=0 and pin_data=0.
- R6: In normal mode, a pin whose disable bit is 0 has pin_oe=1, and pin_data follows that pin's waveform input in the same cycle.
- R7: In manipulation mode (manip_mode=1), every pin has pin_oe=1. pin_data is the pin's fixed level when its disable bit is 1, and its waveform input when the bit is 0.
- R8: When the arm bit is 1, manipulation mode is off and the synchronized shutdown level is low, the next edge sets all four disable bits.
- R9: In manipulation mode the shutdown pin has no effect. The disable bits change only when software writes them.
- R10: A write that clears disable bits in the same cycle as an active force has no effect on the disable bits; the force wins.
- R11: A low on shutdown_n passes two synchronizer flops, so the disable bits become set on the third rising edge after the pin falls.
- R12: A register read returns the live bit values, including bits that the shutdown path has set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Live register contents |
| wave_in | input | 4 | Raw timer waveforms, bit 0 = pin A |
| manip_mode | input | 1 | 1 = output waveform manipulation mode |
| fixed_lvl | input | 4 | Per-pin fixed level used in manipulation mode |
| shutdown_n | input | 1 | Asynchronous external interrupt pin, active low |
| pin_data | output | 4 | Pin output data |
| pin_oe | output | 4 | Pin output enables |

## Verification
The assertions check on every cycle that writes land in the register, that the armed shutdown forces all disable bits, that manipulation mode freezes the disable bits in the absence of a write, and that pin enables match the mode. Some behaviours only the bench scenarios can show against the cycle-accurate reference model. These are the exact three-edge synchronizer latency, a write losing to a force in the same cycle, the constant unassigned bits across writes of zero, and the readback of bits the shutdown path has set.

// File: rtl/pwm_outdis_pkg.sv
package pwm_outdis_pkg;
    localparam int NPIN      = 4;
    localparam int REG_W     = 8;
    localparam int SYNC_LEN  = 2;
    localparam int FILL_W    = REG_W - NPIN - 1;

    typedef struct packed {
        logic            arm;
        logic [NPIN-1:0] dis;
    } ctl_state_t;
endpackage

// File: rtl/pwm_outdis_sync.sv
module pwm_outdis_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_outdis_reg.sv
module pwm_outdis_reg
    import pwm_outdis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             manip,
    input  logic             shut_sync,
    output logic [NPIN-1:0]  dis,
    output logic [REG_W-1:0] rdata
);
    ctl_state_t st_d, st_q;
    logic       force_set;

    always_comb begin
        st_d      = st_q;
        force_set = st_q.arm && !manip && !shut_sync;
        if (we) begin
            st_d.arm = wdata[REG_W-1];
            st_d.dis = wdata[NPIN-1:0];
        end
        if (force_set) st_d.dis = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.arm <= 1'b0;
            st_q.dis <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dis   = st_q.dis;
    assign rdata = {st_q.arm, {FILL_W{1'b1}}, st_q.dis};

    p_wr_dis_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(st_q.arm && !manip && !shut_sync)) |=> (dis == $past(wdata[NPIN-1:0])));
    p_wr_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[REG_W-1] == $past(wdata[REG_W-1])));
    p_force_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[REG_W-1] && !manip && !shut_sync) |=> (&dis));
    p_manip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (manip && !we) |=> $stable(dis));
endmodule

// File: rtl/pwm_outdis_gate.sv
module pwm_outdis_gate
    import pwm_outdis_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] dis,
    input  logic            manip,
    input  logic [NPIN-1:0] wave,
    input  logic [NPIN-1:0] fixed,
    output logic [NPIN-1:0] pdata,
    output logic [NPIN-1:0] poe
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            if (manip) begin
                poe[i]   = 1'b1;
                pdata[i] = dis[i] ? fixed[i] : wave[i];
            end else begin
                poe[i]   = !dis[i];
                pdata[i] = dis[i] ? 1'b0 : wave[i];
            end
        end

        p_norm_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!manip && dis[i]) |-> (!poe[i] && !pdata[i]));
        p_norm_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!manip && !dis[i]) |-> (poe[i] && pdata[i] == wave[i]));
        p_manip_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
            manip |-> (poe[i] && pdata[i] == (dis[i] ? fixed[i] : wave[i])));
    end
endmodule

// File: rtl/pwm_outdis_ctrl.sv
module pwm_outdis_ctrl
    import pwm_outdis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]  wave_in,
    input  logic             manip_mode,
    input  logic [NPIN-1:0]  fixed_lvl,
    input  logic             shutdown_n,
    output logic [NPIN-1:0]  pin_data,
    output logic [NPIN-1:0]  pin_oe
);
    logic            shut_sync;
    logic [NPIN-1:0] dis;

    pwm_outdis_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (shutdown_n),
        .sync_out (shut_sync)
    );

    pwm_outdis_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .manip     (manip_mode),
        .shut_sync (shut_sync),
        .dis       (dis),
        .rdata     (reg_rdata)
    );

    pwm_outdis_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .dis   (dis),
        .manip (manip_mode),
        .wave  (wave_in),
        .fixed (fixed_lvl),
        .pdata (pin_data),
        .poe   (pin_oe)
    );
endmodule

// File: tb/pwm_outdis_ctrl_tb.sv
module pwm_outdis_ctrl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_we = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic [3:0] wave_in = 0;
    logic       manip_mode = 0;
    logic [3:0] fixed_lvl = 0;
    logic       shutdown_n = 1;
    logic [3:0] pin_data, pin_oe;

    int    n_vec = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    bit [3:0] m_dis = 4'hF;
    bit       m_arm = 0;
    bit       m_s1 = 1, m_s2 = 1;

    always #4 clk = ~clk;

    pwm_outdis_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wave_in(wave_in), .manip_mode(manip_mode),
        .fixed_lvl(fixed_lvl), .shutdown_n(shutdown_n),
        .pin_data(pin_data), .pin_oe(pin_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dis = 4'hF; m_arm = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            bit frc;
            frc = m_arm && !manip_mode && !m_s2;
            if (reg_we) begin
                m_dis = reg_wdata[3:0];
                m_arm = reg_wdata[7];
            end
            if (frc) m_dis = 4'hF;
            m_s2 = m_s1;
            m_s1 = shutdown_n;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic [3:0] e_oe, e_dat;
            logic [7:0] e_rd;
            cyc++;
            for (int i = 0; i < 4; i++) begin
                if (manip_mode) begin
                    e_oe[i]  = 1'b1;
                    e_dat[i] = m_dis[i] ? fixed_lvl[i] : wave_in[i];
                end else begin
                    e_oe[i]  = !m_dis[i];
                    e_dat[i] = m_dis[i] ? 1'b0 : wave_in[i];
                end
            end
            e_rd = {m_arm, 3'b111, m_dis};
            n_vec++;
            if (reg_rdata !== e_rd || pin_oe !== e_oe || pin_data !== e_dat) begin
                n_bad++;
                $display("FAIL %s cyc %0d: rdata=%h oe=%b data=%b expected rdata=%h oe=%b data=%b",
                         cur_req, cyc, reg_rdata, pin_oe, pin_data, e_rd, e_oe, e_dat);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] v);
        reg_we = 1; reg_wdata = v;
        tick(1);
        reg_we = 0;
    endtask

    initial begin
        cur_req = "R1 reset";
        tick(3);
        rst_n = 1;
        tick(2);

        cur_req = "R3 R6 enable all, normal mode";
        wr(8'h70);
        for (int k = 0; k < 16; k++) begin wave_in = 4'(k); tick(1); end

        cur_req = "R4 R5 partial disable with arm";
        wr(8'hF5);
        for (int k = 0; k < 8; k++) begin wave_in = 4'(k * 3); tick(1); end

        cur_req = "R2 unassigned bits stay 1";
        wr(8'h00);
        tick(2);
        wr(8'h8A);
        tick(2);

        cur_req = "R7 manipulation mode levels";
        manip_mode = 1; fixed_lvl = 4'b0110;
        for (int k = 0; k < 8; k++) begin wave_in = 4'(k + 5); tick(1); end
        wr(8'hF3);
        for (int k = 0; k < 6; k++) begin fixed_lvl = 4'(k); wave_in = 4'(~k); tick(1); end

        cur_req = "R9 shutdown ignored in manipulation mode";
        shutdown_n = 0;
        tick(6);
        shutdown_n = 1;
        tick(3);
        manip_mode = 0;

        cur_req = "R8 R11 R12 armed shutdown latency and readback";
        wr(8'hF0);
        tick(3);
        wave_in = 4'hF;
        shutdown_n = 0;
        tick(5);
        shutdown_n = 1;
        tick(3);

        cur_req = "R10 force beats clearing write";
        shutdown_n = 0;
        tick(4);
        wr(8'hF0);
        tick(1);
        wr(8'hF0);
        shutdown_n = 1;
        tick(3);
        wr(8'hF0);
        tick(2);

        cur_req = "R8 disarmed shutdown has no effect";
        wr(8'h70);
        shutdown_n = 0;
        tick(5);
        shutdown_n = 1;
        tick(3);

        cur_req = "R11 short low pulse";
        wr(8'hF0);
        tick(2);
        shutdown_n = 0;
        tick(1);
        shutdown_n = 1;
        tick(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule